// File: doc/BRIEF.md
# Way-Predicting Branch Target Buffer

This block is a set-associative branch target buffer. Each entry records the instruction-cache way that last held its fetch block, and a branch target where it has one. A fetch address is looked up in the same cycle it is presented. That one lookup gives both the predicted target and the way hint. When a hint is available, the block enables a single instruction-cache way. Otherwise it enables all of them. This saves tag and data array energy on most fetches.

The table learns from four events:
- A cache fill supplies the correct way. If no entry exists for the fetch address, the fill creates one.
- A cache way mispredict corrects the hint and is counted.
- Branch resolution writes the target.
- A line eviction removes every hint that points at the evicted line.

Branch entries and non-branch entries live in separate halves of the table's ways. Each half has its own replacement state. Non-branch fetches therefore never displace branch targets.

Top module: `btb_waypred`

## Requirements
- R1: After a synchronous active-low reset, no lookup hits, all cache way enables are 1 and the mispredict count is 0.
- R2: A lookup that hits an entry holding a valid hint reports `lk_hit=1` and `lk_pred=1` in the same cycle. It also drives `lk_way_en` one-hot, where bit i enables cache way i and i is the hint.
- R3: A lookup that misses, or that hits an entry without a valid hint, drives `lk_pred=0` and all bits of `lk_way_en` to 1.
- R4: A fill for an address with no entry allocates it in the non-branch half (table ways 2..3) with the filled way as its hint. That entry never reports `lk_tgt_vld`.
- R5: A fill for an address that already has an entry replaces its hint and marks the hint valid.
- R6: A resolve for an address held in the branch half (table ways 0..1) overwrites its target. A resolve for an address held nowhere allocates a branch-half entry with that target and no valid hint. Lookups of branch-half entries report `lk_tgt_vld=1` and the target.
- R7: A resolve for an address held in the non-branch half removes that entry and allocates a branch-half entry. The new entry keeps the old hint and takes the resolved target.
- R8: Within a half, a new entry takes the lowest invalid way. When the half is full, it takes the way not touched most recently. A lookup hit and any write both count as a touch.
- R9: Every mispredict pulse adds 1 to `mp_count`, which saturates at 2^MPC_W-1. A mispredict corrects the hint of an existing entry and allocates nothing for an absent address.
- R10: An eviction of cache set S, way W clears the hint of every entry whose hint is W and whose address maps to cache set S. Other hints stay, and entries and targets stay. The cache set of an address is its bits [10:5].
- R11: At most one table update is applied per cycle, in the priority resolve, mispredict, fill, eviction. Lower-priority requests in that cycle are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | PC_W-IDX_LSB | Fetch word address (bits [31:2]) |
| lk_hit | output | 1 | An entry matches the fetch address |
| lk_pred | output | 1 | The matching entry has a valid way hint |
| lk_way_en | output | CWAYS | Cache way enables |
| lk_way_hint | output | HINT_W | Predicted cache way |
| lk_tgt_vld | output | 1 | The matching entry is a branch with a target |
| lk_target | output | TGT_W | Predicted target |
| fill_valid | input | 1 | Cache fill event |
| fill_addr | input | PC_W-IDX_LSB | Address of the filled fetch block |
| fill_way | input | HINT_W | Cache way that received the line |
| mp_valid | input | 1 | Way mispredict event |
| mp_addr | input | PC_W-IDX_LSB | Address whose hint was wrong |
| mp_way | input | HINT_W | Correct cache way |
| mp_count | output | MPC_W | Saturating mispredict count |
| rs_valid | input | 1 | Branch resolution event |
| rs_addr | input | PC_W-IDX_LSB | Branch address |
| rs_target | input | TGT_W | Resolved target |
| ev_valid | input | 1 | Cache eviction event |
| ev_set | input | CSET_W | Evicted cache set |
| ev_way | input | HINT_W | Evicted cache way |

## Verification
The bound assertions check on every cycle:
- the way-enable shape: one-hot when a hint is used, all ones otherwise;
- that a target is reported only on a hit;
- the increment and hold rules of the mispredict count;
- the cleared state right after reset.

Allocation partition, LRU victim choice, migration from the non-branch to the branch half, selective hint clearing on eviction and update priority all depend on earlier history. Only the bench's ordered scenarios can show these, by looking up addresses after chosen sequences of events.

// File: rtl/btb_waypred_pkg.sv
// Shared types for the way-predicting BTB.
// Assumes: one table update is selected per cycle from the event inputs.
package btb_waypred_pkg;
    typedef enum logic [2:0] {
        UPD_NONE = 3'd0,
        UPD_EV   = 3'd1,
        UPD_FILL = 3'd2,
        UPD_MP   = 3'd3,
        UPD_RS   = 3'd4
    } upd_op_e;
endpackage

// File: rtl/btb_waypred_match.sv
// Tag comparator for one table set.
// Reports whether any valid way matches, and the lowest matching way.
// Assumes at most one way matches; allocation keeps tags unique per set.
module btb_waypred_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 24,
    localparam int WIDX_W = $clog2(WAYS)
) (
    input  logic [TAG_W-1:0]  tag_i,
    input  logic [WAYS-1:0]   vld_i,
    input  logic [TAG_W-1:0]  tags_i [WAYS],
    output logic              hit_o,
    output logic [WIDX_W-1:0] way_o
);
    logic [WAYS-1:0] eq;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign eq[w] = vld_i[w] && (tags_i[w] == tag_i);
    end

    // Reduce the per-way matches to a hit flag and the lowest matching index.
    always_comb begin
        hit_o = |eq;
        way_o = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (eq[w]) way_o = WIDX_W'(w);
        end
    end
endmodule

// File: rtl/btb_waypred_victim.sv
// Victim choice inside one partition of a set.
// Takes the lowest invalid way; if the partition is full, takes the way under
// the replacement pointer.
// Assumes PW is a power of two and at least 2.
module btb_waypred_victim #(
    parameter int PW = 2,
    localparam int PTR_W = $clog2(PW)
) (
    input  logic [PW-1:0]    vld_i,
    input  logic [PTR_W-1:0] ptr_i,
    output logic [PTR_W-1:0] vic_o
);
    // Free ways win over the pointer; the lowest free index wins.
    always_comb begin
        vic_o = ptr_i;
        for (int w = PW - 1; w >= 0; w--) begin
            if (!vld_i[w]) vic_o = PTR_W'(w);
        end
    end
endmodule

// File: rtl/btb_waypred_misscnt.sv
// Saturating counter of way mispredicts (each one costs a redo cycle).
// Assumes inc_i is high for one cycle per event.
module btb_waypred_misscnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    output logic [CNT_W-1:0] cnt_o
);
    // Count events and stick at the all-ones value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else if (inc_i && (cnt_o != '1)) begin
            cnt_o <= cnt_o + CNT_W'(1);
        end
    end
endmodule

// File: rtl/btb_waypred.sv
// Way-predicting BTB, top level.
// Every entry carries a cache-way hint; branch targets are kept only in the
// lower half of the ways, non-branch fetch entries only in the upper half.
// Lookup is combinational from the table state. Exactly one table update is
// applied per cycle, in the priority resolve > mispredict > fill > eviction.
// Assumes PART_WAYS is a power of two and at least 2, and that
// TAG_W = PC_W - IDX_LSB - SET_W is positive.
module btb_waypred
    import btb_waypred_pkg::*;
#(
    parameter int PC_W      = 32,
    parameter int IDX_LSB   = 2,
    parameter int SETS      = 64,
    parameter int PART_WAYS = 2,
    parameter int CWAYS     = 4,
    parameter int CSETS     = 64,
    parameter int CLINE_LSB = 5,
    parameter int TGT_W     = 32,
    parameter int MPC_W     = 8,
    localparam int SET_W    = $clog2(SETS),
    localparam int TAG_W    = PC_W - IDX_LSB - SET_W,
    localparam int HINT_W   = $clog2(CWAYS),
    localparam int CSET_W   = $clog2(CSETS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    lk_valid,
    input  logic [PC_W-1:IDX_LSB]   lk_addr,
    output logic                    lk_hit,
    output logic                    lk_pred,
    output logic [CWAYS-1:0]        lk_way_en,
    output logic [HINT_W-1:0]       lk_way_hint,
    output logic                    lk_tgt_vld,
    output logic [TGT_W-1:0]        lk_target,
    input  logic                    fill_valid,
    input  logic [PC_W-1:IDX_LSB]   fill_addr,
    input  logic [HINT_W-1:0]       fill_way,
    input  logic                    mp_valid,
    input  logic [PC_W-1:IDX_LSB]   mp_addr,
    input  logic [HINT_W-1:0]       mp_way,
    output logic [MPC_W-1:0]        mp_count,
    input  logic                    rs_valid,
    input  logic [PC_W-1:IDX_LSB]   rs_addr,
    input  logic [TGT_W-1:0]        rs_target,
    input  logic                    ev_valid,
    input  logic [CSET_W-1:0]       ev_set,
    input  logic [HINT_W-1:0]       ev_way
);
    localparam int WAYS   = 2 * PART_WAYS;
    localparam int WIDX_W = $clog2(WAYS);
    localparam int PTR_W  = $clog2(PART_WAYS);

    // Table state
    logic [WAYS-1:0]   vld_q  [SETS];
    logic [WAYS-1:0]   hv_q   [SETS];
    logic [PTR_W-1:0]  ptr_q  [SETS][2];
    logic [TAG_W-1:0]  tag_q  [SETS][WAYS];
    logic [HINT_W-1:0] hint_q [SETS][WAYS];
    logic [TGT_W-1:0]  tgt_q  [SETS][WAYS];

    // Cache set that the address {tag, set} maps to.
    function automatic logic [CSET_W-1:0] cset_of(input logic [TAG_W-1:0] t,
                                                   input logic [SET_W-1:0] s);
        return CSET_W'({t, s, {IDX_LSB{1'b0}}} >> CLINE_LSB);
    endfunction

    // ---------------- lookup path ----------------
    logic [SET_W-1:0]  lk_set;
    logic [TAG_W-1:0]  lk_tag;
    logic [TAG_W-1:0]  lk_tags [WAYS];
    logic              lk_any;
    logic [WIDX_W-1:0] lk_w;

    assign lk_set = lk_addr[IDX_LSB +: SET_W];
    assign lk_tag = lk_addr[PC_W-1 -: TAG_W];

    // Gather the tags of the looked-up set.
    always_comb begin
        for (int w = 0; w < WAYS; w++) lk_tags[w] = tag_q[lk_set][w];
    end

    btb_waypred_match #(.WAYS(WAYS), .TAG_W(TAG_W)) lk_match_i (
        .tag_i(lk_tag), .vld_i(vld_q[lk_set]), .tags_i(lk_tags),
        .hit_o(lk_any), .way_o(lk_w)
    );

    // Form hit, hint, way enables and target for the fetch.
    always_comb begin
        lk_hit      = lk_valid && lk_any;
        lk_way_hint = hint_q[lk_set][lk_w];
        lk_pred     = lk_hit && hv_q[lk_set][lk_w];
        lk_tgt_vld  = lk_hit && !lk_w[WIDX_W-1];
        lk_target   = tgt_q[lk_set][lk_w];
        for (int c = 0; c < CWAYS; c++) begin
            lk_way_en[c] = !lk_pred || (lk_way_hint == HINT_W'(c));
        end
    end

    // ---------------- update path ----------------
    upd_op_e                op;
    logic [PC_W-1:IDX_LSB]  u_addr;
    logic [HINT_W-1:0]      u_way;
    logic [SET_W-1:0]       u_set;
    logic [TAG_W-1:0]       u_tag;
    logic [TAG_W-1:0]       u_tags [WAYS];
    logic                   u_any;
    logic [WIDX_W-1:0]      u_w;
    logic [PTR_W-1:0]       vic [2];
    logic [WIDX_W-1:0]      br_w;
    logic [WIDX_W-1:0]      nb_w;

    // Pick the single event applied this cycle.
    always_comb begin
        op     = UPD_NONE;
        u_addr = fill_addr;
        u_way  = fill_way;
        if (rs_valid) begin
            op     = UPD_RS;
            u_addr = rs_addr;
        end else if (mp_valid) begin
            op     = UPD_MP;
            u_addr = mp_addr;
            u_way  = mp_way;
        end else if (fill_valid) begin
            op = UPD_FILL;
        end else if (ev_valid) begin
            op = UPD_EV;
        end
    end

    assign u_set = u_addr[IDX_LSB +: SET_W];
    assign u_tag = u_addr[PC_W-1 -: TAG_W];

    // Gather the tags of the updated set.
    always_comb begin
        for (int w = 0; w < WAYS; w++) u_tags[w] = tag_q[u_set][w];
    end

    btb_waypred_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match_i (
        .tag_i(u_tag), .vld_i(vld_q[u_set]), .tags_i(u_tags),
        .hit_o(u_any), .way_o(u_w)
    );

    for (genvar p = 0; p < 2; p++) begin : g_part
        btb_waypred_victim #(.PW(PART_WAYS)) vic_i (
            .vld_i(vld_q[u_set][p*PART_WAYS +: PART_WAYS]),
            .ptr_i(ptr_q[u_set][p]),
            .vic_o(vic[p])
        );
    end

    assign br_w = {1'b0, vic[0]};
    assign nb_w = {1'b1, vic[1]};

    // Eviction match: valid hint, same cache way, same cache set.
    logic [WAYS-1:0] ev_clr [SETS];
    for (genvar s = 0; s < SETS; s++) begin : g_ev_s
        for (genvar w = 0; w < WAYS; w++) begin : g_ev_w
            assign ev_clr[s][w] = vld_q[s][w] && hv_q[s][w] && (hint_q[s][w] == ev_way)
                                  && (cset_of(tag_q[s][w], SET_W'(s)) == ev_set);
        end
    end

    // Control state: valid bits, hint-valid bits and replacement pointers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                vld_q[s]    <= '0;
                hv_q[s]     <= '0;
                ptr_q[s][0] <= '0;
                ptr_q[s][1] <= '0;
            end
        end else begin
            if (lk_hit) ptr_q[lk_set][lk_w[WIDX_W-1]] <= lk_w[PTR_W-1:0] + PTR_W'(1);
            case (op)
                UPD_RS: begin
                    if (u_any && !u_w[WIDX_W-1]) begin
                        ptr_q[u_set][0] <= u_w[PTR_W-1:0] + PTR_W'(1);
                    end else begin
                        if (u_any) vld_q[u_set][u_w] <= 1'b0;
                        vld_q[u_set][br_w] <= 1'b1;
                        hv_q[u_set][br_w]  <= u_any && hv_q[u_set][u_w];
                        ptr_q[u_set][0]    <= vic[0] + PTR_W'(1);
                    end
                end
                UPD_MP, UPD_FILL: begin
                    if (u_any) begin
                        hv_q[u_set][u_w] <= 1'b1;
                        ptr_q[u_set][u_w[WIDX_W-1]] <= u_w[PTR_W-1:0] + PTR_W'(1);
                    end else if (op == UPD_FILL) begin
                        vld_q[u_set][nb_w] <= 1'b1;
                        hv_q[u_set][nb_w]  <= 1'b1;
                        ptr_q[u_set][1]    <= vic[1] + PTR_W'(1);
                    end
                end
                UPD_EV: begin
                    for (int s = 0; s < SETS; s++) hv_q[s] <= hv_q[s] & ~ev_clr[s];
                end
                default: ;
            endcase
        end
    end

    // Payload state: tags, hints and targets (no reset needed).
    always_ff @(posedge clk) begin
        case (op)
            UPD_RS: begin
                if (u_any && !u_w[WIDX_W-1]) begin
                    tgt_q[u_set][u_w] <= rs_target;
                end else begin
                    tag_q[u_set][br_w]  <= u_tag;
                    tgt_q[u_set][br_w]  <= rs_target;
                    hint_q[u_set][br_w] <= hint_q[u_set][u_w];
                end
            end
            UPD_MP, UPD_FILL: begin
                if (u_any) begin
                    hint_q[u_set][u_w] <= u_way;
                end else if (op == UPD_FILL) begin
                    tag_q[u_set][nb_w]  <= u_tag;
                    hint_q[u_set][nb_w] <= u_way;
                    tgt_q[u_set][nb_w]  <= '0;
                end
            end
            default: ;
        endcase
    end

    btb_waypred_misscnt #(.CNT_W(MPC_W)) mpc_i (
        .clk(clk), .rst_n(rst_n), .inc_i(mp_valid), .cnt_o(mp_count)
    );
endmodule

// File: rtl/btb_waypred_chk.sv
// Property checker for the way-predicting BTB, bound to every instance.
// Assumes synchronous active-low reset held low from time zero.
module btb_waypred_chk #(
    parameter int CWAYS = 4,
    parameter int MPC_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lk_hit,
    input logic             lk_pred,
    input logic             lk_tgt_vld,
    input logic [CWAYS-1:0] lk_way_en,
    input logic             mp_valid,
    input logic [MPC_W-1:0] mp_count
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!lk_hit && (mp_count == '0)));

    // R2
    pred_single_way_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_pred |-> (lk_hit && ($countones(lk_way_en) == 1)));

    // R3
    nopred_all_ways_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_pred |-> (lk_way_en == '1));

    // R4
    target_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_tgt_vld |-> lk_hit);

    // R9
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mp_valid && (mp_count != '1)) |=> (mp_count == $past(mp_count) + MPC_W'(1)));

    // R9
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mp_valid || (mp_count == '1)) |=> $stable(mp_count));
endmodule

bind btb_waypred btb_waypred_chk #(.CWAYS(CWAYS), .MPC_W(MPC_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .lk_hit(lk_hit), .lk_pred(lk_pred),
    .lk_tgt_vld(lk_tgt_vld), .lk_way_en(lk_way_en),
    .mp_valid(mp_valid), .mp_count(mp_count)
);

// File: tb/btb_waypred_tb_top.sv
// Bench for the way-predicting BTB: a vector table walked in order, then
// directed tests for priority, counter saturation and reset.
module btb_waypred_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid, fill_valid, mp_valid, rs_valid, ev_valid;
    logic [31:2] lk_addr, fill_addr, mp_addr, rs_addr;
    logic [1:0]  fill_way, mp_way, ev_way, lk_way_hint;
    logic [5:0]  ev_set;
    logic [31:0] rs_target, lk_target;
    logic        lk_hit, lk_pred, lk_tgt_vld;
    logic [3:0]  lk_way_en;
    logic [7:0]  mp_count;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    btb_waypred dut_i (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr),
        .lk_hit(lk_hit), .lk_pred(lk_pred), .lk_way_en(lk_way_en),
        .lk_way_hint(lk_way_hint), .lk_tgt_vld(lk_tgt_vld), .lk_target(lk_target),
        .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_way(fill_way),
        .mp_valid(mp_valid), .mp_addr(mp_addr), .mp_way(mp_way), .mp_count(mp_count),
        .rs_valid(rs_valid), .rs_addr(rs_addr), .rs_target(rs_target),
        .ev_valid(ev_valid), .ev_set(ev_set), .ev_way(ev_way)
    );

    localparam logic [2:0] T_CHK = 3'd0, T_FILL = 3'd1, T_MP = 3'd2, T_RS = 3'd3, T_EV = 3'd4;
    // Addresses: A, B, C, D share table set 5 and cache set 0.
    localparam logic [31:0] PA = 32'h0000_1014, PB = 32'h0000_2014, PC = 32'h0000_3014;
    localparam logic [31:0] PD = 32'h0000_4014;
    localparam logic [31:0] PE = 32'h0000_0124;  // cache set 9
    localparam logic [31:0] PF = 32'h0000_5018;  // table set 6, cache set 0

    typedef struct packed {
        logic [2:0]  op;
        logic [31:0] pc;
        logic [31:0] arg;
        logic        hit;
        logic        pred;
        logic [3:0]  wen;
        logic        tv;
        logic [31:0] tgt;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t VECS [NV] = '{
        '{T_CHK,  PA, 32'h0, 1'b0, 1'b0, 4'hF, 1'b0, 32'h0, 4'd3},     // R3 empty miss
        '{T_FILL, PA, 32'd2, 1'b0, 1'b0, 4'h0, 1'b0, 32'h0, 4'd4},
        '{T_CHK,  PA, 32'h0, 1'b1, 1'b1, 4'h4, 1'b0, 32'h0, 4'd4},     // R4 allocated, no target
        '{T_FILL, PB, 32'd1, 1'b0, 1'b0, 4'h0, 1'b0, 32'h0, 4'd4},
        '{T_CHK,  PB, 32'h0, 1'b1, 1'b1, 4'h2, 1'b0, 32'h0, 4'd4},     // R4
        '{T_CHK,  PA, 32'h0, 1'b1, 1'b1, 4'h4, 1'b0, 32'h0, 4'd2},     // R2 touch A
        '{T_FILL, PC, 32'd3, 1'b0, 1'b0, 4'h0, 1'b0, 32'h0, 4'd8},
        '{T_CHK,  PB, 32'h0, 1'b0, 1'b0, 4'hF, 1'b0, 32'h0, 4'd8},     // R8 B was the victim
        '{T_CHK,  PA, 32'h0, 1'b1, 1'b1, 4'h4, 1'b0, 32'h0, 4'd8},     // R8
        '{T_CHK,  PC, 32'h0, 1'b1, 1'b1, 4'h8, 1'b0, 32'h0, 4'd8},     // R8
        '{T_FILL, PA, 32'd0, 1'b0, 1'b0, 4'h0, 1'b0, 32'h0, 4'd5},
        '{T_CHK,  PA, 32'h0, 1'b1, 1'b1, 4'h1, 1'b0, 32'h0, 4'd5},     // R5 hint replaced
        '{T_MP,   PA, 32'd3, 1'b0, 1'b0, 4'h0, 1'b0, 32'h0, 4'd9},
        '{T_CHK,  PA, 32'h0, 1'b1, 1'b1, 4'h8, 1'b0, 32'h0, 4'd9},     // R9 hint corrected
        '{T_RS,   PD, 32'h8000, 1'b0, 1'b0, 4'h0, 1'b0, 32'h0, 4'd6},
        '{T_CHK,  PD, 32'h0, 1'b1, 1'b0, 4'hF, 1'b1, 32'h8000, 4'd6}, // R6 new branch, no hint
        '{T_RS,   PD, 32'h9000, 1'b0, 1'b0, 4'h0, 1'b0, 32'h0, 4'd6},
        '{T_CHK,  PD, 32'h0, 1'b1, 1'b0, 4'hF, 1'b1, 32'h9000, 4'd6}, // R6 target updated
        '{T_RS,   PA, 32'hA000, 1'b0, 1'b0, 4'h0, 1'b0, 32'h0, 4'd7},
        '{T_CHK,  PA, 32'h0, 1'b1, 1'b1, 4'h8, 1'b1, 32'hA000, 4'd7}, // R7 migrated, hint kept
        '{T_FILL, PE, 32'd3, 1'b0, 1'b0, 4'h0, 1'b0, 32'h0, 4'd10},
        '{T_FILL, PF, 32'd1, 1'b0, 1'b0, 4'h0, 1'b0, 32'h0, 4'd10},
        '{T_EV,   32'h0, 32'h3, 1'b0, 1'b0, 4'h0, 1'b0, 32'h0, 4'd10}, // cache set 0, way 3
        '{T_CHK,  PA, 32'h0, 1'b1, 1'b0, 4'hF, 1'b1, 32'hA000, 4'd10}, // R10 hint cleared
        '{T_CHK,  PC, 32'h0, 1'b1, 1'b0, 4'hF, 1'b0, 32'h0, 4'd10},    // R10 hint cleared
        '{T_CHK,  PE, 32'h0, 1'b1, 1'b1, 4'h8, 1'b0, 32'h0, 4'd10},    // R10 other set kept
        '{T_CHK,  PF, 32'h0, 1'b1, 1'b1, 4'h2, 1'b0, 32'h0, 4'd10}     // R10 other way kept
    };

    task automatic idle_inputs();
        lk_valid = 1'b0; fill_valid = 1'b0; mp_valid = 1'b0; rs_valid = 1'b0; ev_valid = 1'b0;
        lk_addr = '0; fill_addr = '0; mp_addr = '0; rs_addr = '0;
        fill_way = '0; mp_way = '0; ev_way = '0; ev_set = '0; rs_target = '0;
    endtask

    // Drive one event for one cycle.
    task automatic apply(input logic [2:0] op, input logic [31:0] pc, input logic [31:0] arg);
        @(negedge clk);
        idle_inputs();
        case (op)
            T_FILL: begin fill_valid = 1'b1; fill_addr = pc[31:2]; fill_way = arg[1:0]; end
            T_MP:   begin mp_valid = 1'b1; mp_addr = pc[31:2]; mp_way = arg[1:0]; end
            T_RS:   begin rs_valid = 1'b1; rs_addr = pc[31:2]; rs_target = arg; end
            T_EV:   begin ev_valid = 1'b1; ev_set = arg[7:2]; ev_way = arg[1:0]; end
            default: ;
        endcase
        @(negedge clk);
        idle_inputs();
    endtask

    // Present a lookup and compare its outputs (the lookup touches the LRU at the next edge).
    task automatic look(input logic [31:0] pc, input logic ehit, input logic epred,
                        input logic [3:0] ewen, input logic etv, input logic [31:0] etgt,
                        input string rq);
        @(negedge clk);
        idle_inputs();
        lk_valid = 1'b1;
        lk_addr  = pc[31:2];
        #1;
        n_chk++;
        if (lk_hit !== ehit || lk_pred !== epred || lk_way_en !== ewen || lk_tgt_vld !== etv
            || (etv && lk_target !== etgt)) begin
            n_bad++;
            $display("FAIL %s pc=%h: hit/pred/wen/tv/tgt = %b/%b/%h/%b/%h expected %b/%b/%h/%b/%h",
                     rq, pc, lk_hit, lk_pred, lk_way_en, lk_tgt_vld, lk_target,
                     ehit, epred, ewen, etv, etgt);
        end
    endtask

    task automatic check_count(input logic [7:0] exp, input string rq);
        @(negedge clk);
        idle_inputs();
        #1;
        n_chk++;
        if (mp_count !== exp) begin
            n_bad++;
            $display("FAIL %s mp_count=%0d expected %0d", rq, mp_count, exp);
        end
    endtask

    initial begin
        idle_inputs();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check_count(8'd0, "R1");
        look(PA, 1'b0, 1'b0, 4'hF, 1'b0, 32'h0, "R1");

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].op == T_CHK)
                look(VECS[i].pc, VECS[i].hit, VECS[i].pred, VECS[i].wen, VECS[i].tv,
                     VECS[i].tgt, $sformatf("R%0d", VECS[i].rq));
            else
                apply(VECS[i].op, VECS[i].pc, VECS[i].arg);
        end
        check_count(8'd1, "R9");

        // R11: resolve and fill together -> only the resolve lands.
        @(negedge clk);
        idle_inputs();
        rs_valid = 1'b1; rs_addr = 30'h0000_0050 >> 2; rs_target = 32'h0000_C000;
        fill_valid = 1'b1; fill_addr = 30'h0000_0150 >> 2; fill_way = 2'd1;
        look(32'h0000_0050, 1'b1, 1'b0, 4'hF, 1'b1, 32'h0000_C000, "R11");
        look(32'h0000_0150, 1'b0, 1'b0, 4'hF, 1'b0, 32'h0, "R11");
        // R11: fill and eviction of the same line together -> fill wins, hint survives.
        @(negedge clk);
        idle_inputs();
        fill_valid = 1'b1; fill_addr = 30'h0000_0060 >> 2; fill_way = 2'd2;
        ev_valid = 1'b1; ev_set = 6'd3; ev_way = 2'd2;
        look(32'h0000_0060, 1'b1, 1'b1, 4'h4, 1'b0, 32'h0, "R11");

        // R9: saturation, and no allocation for an absent address.
        @(negedge clk);
        idle_inputs();
        mp_valid = 1'b1; mp_addr = 30'h0000_0070 >> 2; mp_way = 2'd1;
        repeat (260) @(negedge clk);
        idle_inputs();
        check_count(8'd255, "R9");
        look(32'h0000_0070, 1'b0, 1'b0, 4'hF, 1'b0, 32'h0, "R9");

        // R1: reset in the middle of operation clears everything.
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check_count(8'd0, "R1");
        look(PD, 1'b0, 1'b0, 4'hF, 1'b0, 32'h0, "R1");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule